// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog counter clocked directly by the system clock. Software is expected to restart it now and then. If it is not restarted before the selected timeout runs out, the block first raises an early-warning flag. An interrupt request follows from that flag when interrupts are enabled. If software still does not restart the counter during a fixed grace window after the warning, the block sends out a one-cycle system reset pulse, provided the reset enable is set.

The timeout is picked by a 2-bit select. The timeout lengths are powers of two of the system clock: 2^15, 2^18, 2^21 and 2^24 clocks with the default parameters, and the grace window is 512 clocks. A new select value is taken over only at a restart, so changing it cannot cause an early expiry. At the end of the grace window the counter goes back to zero whether or not a reset pulse was produced, and a new timeout period begins.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, wdFlag, wdIrq and sysRstPulse are 0, the count is zero, and the active timeout is that of select code 00, whatever tmoSel holds.
- R2: The active timeout is T = 2^(BASE_EXP + EXP_STEP*s) clocks for select code s (s = 0..3; 2^15, 2^18, 2^21, 2^24 by default). Call the edge that samples a restart edge 0. wdFlag rises at edge T.
- R3: wdIrq equals wdFlag AND irqEn at all times.
- R4: wdFlag stays set until an edge samples flagClear high. If a timeout and flagClear fall on the same edge, the flag is set.
- R5: With sysRstEn high, sysRstPulse is high for exactly one cycle, beginning at edge T + GRACE after the last restart (GRACE is 512 by default).
- R6: A restart sampled at any edge clears the count. This includes a restart inside the grace window. No flag and no reset pulse come from the period that the restart ended.
- R7: A change of tmoSel without a restart has no effect. The select value sampled together with a restart becomes the active timeout.
- R8: With sysRstEn low, no reset pulse is produced. The count still goes back to zero at edge T + GRACE, so the flag sets again at edge 2T + GRACE.
- R9: After a reset pulse the count starts again from zero. The next flag comes T edges after the pulse edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmoSel | input | SEL_W | Timeout select, taken over at a restart |
| irqEn | input | 1 | Interrupt enable |
| sysRstEn | input | 1 | Enables the system reset pulse |
| restart | input | 1 | Software restart strobe |
| flagClear | input | 1 | Clears the sticky warning flag |
| wdFlag | output | 1 | Sticky early-warning flag |
| wdIrq | output | 1 | Interrupt request (flag gated by enable) |
| sysRstPulse | output | 1 | One-cycle system reset pulse |

## Verification
The hardest state to reach from the ports is the grace window itself. This covers a restart that lands between the warning and the reset, a clear that coincides with a timeout, and a select change made while a period is running. Periods of millions of clocks are out of reach, so the bench shrinks the exponents and the grace window through parameters. Directed sequences then place restarts, clears and select changes at chosen offsets inside that window. Random restart, clear and enable traffic runs alongside, and every cycle is compared with a bench model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes sent from the control module to the datapath each cycle.
  typedef struct packed {
    logic clrCnt;   // return the count to zero
    logic loadSel;  // take over the external select
    logic setFlag;  // set the warning flag
    logic clrFlag;  // clear the warning flag
  } wdStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 15,
  parameter int EXP_STEP = 3,
  parameter int GRACE    = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  wdStrobe_t        strb,
  output logic             timeoutHit,
  output logic             graceHit,
  output logic             flag
);

  localparam int NUM_SEL = 1 << SEL_W;
  localparam int MAX_EXP = BASE_EXP + EXP_STEP * (NUM_SEL - 1);
  localparam int CNT_W   = MAX_EXP + 1;
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] GRACE_C = CNT_W'(GRACE);

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] activeSel;
  logic [CNT_W-1:0] limitTab [NUM_SEL];
  logic [CNT_W-1:0] selLimit;

  // One timeout length per select code.
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_limit
    assign limitTab[i] = ONE_C << (BASE_EXP + EXP_STEP * i);
  end

  assign selLimit   = limitTab[activeSel];
  assign timeoutHit = (cnt == selLimit - ONE_C);
  assign graceHit   = (cnt == selLimit + GRACE_C - ONE_C);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clrCnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE_C;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSel <= '0;
    end else if (strb.loadSel) begin
      activeSel <= selIn;
    end
  end

  // A set has priority over a clear, so a timeout is never lost.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (strb.setFlag) begin
      flag <= 1'b1;
    end else if (strb.clrFlag) begin
      flag <= 1'b0;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadSel |=> $stable(activeSel)); // R7
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cnt == '0)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strb.clrFlag) |=> flag); // R4
  AST_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(timeoutHit)); // R2

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      kickIn,
  input  logic      flagClrIn,
  input  logic      rstEnIn,
  input  logic      timeoutHit,
  input  logic      graceHit,
  output wdStrobe_t strb,
  output logic      rstPulse
);

  logic fireRst;

  // A restart pre-empts both stages of the period it ends.
  always_comb begin
    strb.clrCnt  = kickIn | graceHit;
    strb.loadSel = kickIn;
    strb.setFlag = timeoutHit & ~kickIn;
    strb.clrFlag = flagClrIn;
    fireRst      = graceHit & ~kickIn & rstEnIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPulse <= 1'b0;
    end else begin
      rstPulse <= fireRst;
    end
  end

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> !rstPulse); // R5
  AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |-> $past(rstEnIn)); // R8
  AST_KICK_BLOCKS_RST: assert property (@(posedge clk) disable iff (!rstN)
    kickIn |=> !rstPulse); // R6

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int BASE_EXP = 15,
  parameter int EXP_STEP = 3,
  parameter int GRACE    = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] tmoSel,
  input  logic             irqEn,
  input  logic             sysRstEn,
  input  logic             restart,
  input  logic             flagClear,
  output logic             wdFlag,
  output logic             wdIrq,
  output logic             sysRstPulse
);

  wdStrobe_t strb;
  logic      timeoutHit;
  logic      graceHit;

  wdog_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .kickIn     (restart),
    .flagClrIn  (flagClear),
    .rstEnIn    (sysRstEn),
    .timeoutHit (timeoutHit),
    .graceHit   (graceHit),
    .strb       (strb),
    .rstPulse   (sysRstPulse)
  );

  wdog_datapath #(
    .SEL_W    (SEL_W),
    .BASE_EXP (BASE_EXP),
    .EXP_STEP (EXP_STEP),
    .GRACE    (GRACE)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .selIn      (tmoSel),
    .strb       (strb),
    .timeoutHit (timeoutHit),
    .graceHit   (graceHit),
    .flag       (wdFlag)
  );

  assign wdIrq = wdFlag & irqEn;

  AST_NO_RST_WITH_KICK_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> !$past(restart)); // R6

endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

  localparam int SW   = 2;
  localparam int BASE = 6;
  localparam int STEP = 2;
  localparam int G    = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic [SW-1:0] tmoSel = '0;
  logic          irqEn = 1'b0, sysRstEn = 1'b0, restart = 1'b0, flagClear = 1'b0;
  logic          wdFlag, wdIrq, sysRstPulse;

  wdog_two_stage #(.SEL_W(SW), .BASE_EXP(BASE), .EXP_STEP(STEP), .GRACE(G)) i_wdog_two_stage (
    .clk(clk), .rstN(rstN), .tmoSel(tmoSel), .irqEn(irqEn), .sysRstEn(sysRstEn),
    .restart(restart), .flagClear(flagClear), .wdFlag(wdFlag), .wdIrq(wdIrq),
    .sysRstPulse(sysRstPulse)
  );

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;

  // Model built from the requirements
  int          mCnt;
  logic [SW-1:0] mSel;
  logic        mFlag, mRst;

  function automatic int limitOf(input logic [SW-1:0] s);
    return 1 << (BASE + STEP * int'(s));
  endfunction

  always @(posedge clk) begin
    int t;
    bit tHit, gEnd;
    cyc++;
    if (!rstN) begin
      mCnt = 0; mSel = '0; mFlag = 0; mRst = 0;
    end else begin
      t = limitOf(mSel);
      tHit = (mCnt == t - 1);
      gEnd = (mCnt == t + G - 1);
      mRst = gEnd && !restart && sysRstEn;
      if (tHit && !restart) mFlag = 1;
      else if (flagClear) mFlag = 0;
      mCnt = (restart || gEnd) ? 0 : mCnt + 1;
      if (restart) mSel = tmoSel;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic checkInt(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock; outputs compared with the model at the falling edge.
  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, "wdFlag", wdFlag, mFlag);
    check("R3", "wdIrq", wdIrq, mFlag & irqEn);
    check(req, "sysRstPulse", sysRstPulse, mRst);
  endtask

  task automatic kick(input string req, input logic [SW-1:0] s);
    tmoSel = s; restart = 1; flagClear = 1;
    tick(req);
    restart = 0; flagClear = 0;
  endtask

  task automatic waitFlag(input string req, output int n);
    n = 0;
    do begin tick(req); n++; end while (!wdFlag && n < 20000);
  endtask

  task automatic waitRst(input string req, output int n);
    n = 0;
    do begin tick(req); n++; end while (!sysRstPulse && n < 20000);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 200000) begin
      errs++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    // R1: reset state, select held at 11 during reset
    tmoSel = 2'b11;
    repeat (3) @(negedge clk);
    check("R1", "flag in reset", wdFlag, 0);
    check("R1", "irq in reset", wdIrq, 0);
    check("R1", "rst in reset", sysRstPulse, 0);
    rstN = 1;
    // R1/R7: active select is 00 after reset, although tmoSel is 11
    irqEn = 1;
    waitFlag("R1", n);
    checkInt("R1", "first timeout after reset", n, limitOf(2'b00));
    // R5: pulse GRACE clocks after the flag
    sysRstEn = 1;
    waitRst("R5", n);
    checkInt("R5", "grace length", n, G);
    tick("R5");
    check("R5", "pulse width one", sysRstPulse, 0);
    // R9: the count restarts after the pulse
    flagClear = 1; tick("R9"); flagClear = 0;
    waitFlag("R9", n);
    checkInt("R9", "timeout after pulse", n + 1, limitOf(2'b00) - 1);
    // R7: select 01 taken at restart; later change to 11 ignored
    kick("R7", 2'b01);
    tmoSel = 2'b11;
    waitFlag("R7", n);
    checkInt("R7", "timeout with sel 01", n, limitOf(2'b01));
    // R6: restart inside grace window suppresses the reset
    repeat (G / 2) tick("R6");
    kick("R6", 2'b00);
    waitFlag("R6", n);
    checkInt("R6", "timeout after grace restart", n, limitOf(2'b00));
    repeat (G - 2) tick("R6");
    kick("R6", 2'b00);
    check("R6", "no pulse after late restart", sysRstPulse, 0);
    // R2: select 10
    kick("R2", 2'b10);
    waitFlag("R2", n);
    checkInt("R2", "timeout with sel 10", n, limitOf(2'b10));
    // R4: clear held through the timeout; set wins, then clear
    kick("R4", 2'b00);
    flagClear = 1;
    waitFlag("R4", n);
    checkInt("R4", "set wins over clear", n, limitOf(2'b00));
    tick("R4");
    check("R4", "cleared after set", wdFlag, 0);
    flagClear = 0;
    // R3: irq gating
    irqEn = 0;
    kick("R3", 2'b00);
    waitFlag("R3", n);
    check("R3", "irq masked", wdIrq, 0);
    irqEn = 1;
    #1 check("R3", "irq unmasked", wdIrq, 1);
    // R8: no pulse without enable, period repeats
    sysRstEn = 0;
    kick("R8", 2'b00);
    waitFlag("R8", n);
    flagClear = 1; tick("R8"); flagClear = 0;
    waitFlag("R8", n);
    checkInt("R8", "second flag spacing", n + 1, limitOf(2'b00) + G);
    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      restart   = ($urandom % 300) == 0;
      flagClear = ($urandom % 50) == 0;
      tmoSel    = SW'($urandom);
      if (($urandom % 400) == 0) irqEn = ~irqEn;
      if (($urandom % 400) == 0) sysRstEn = ~sysRstEn;
      tick("R6");
    end
    summary();
  end

endmodule